// File: doc/BRIEF.md
# Program Counter Sequencer with Fetch Mapping and Repeat Loop

This block keeps the word-addressed program counter of a small processor core. It moves the counter forward by one word per instruction, loads a branch target when a branch is taken, and runs a zero-overhead repeat loop. The loop is set up with a start word, an end word and a pass count. Each time the instruction at the end word completes while the loop is armed, the counter goes back to the start word without a branch instruction, until the last pass lets it fall through.

The block also turns the counter into a physical fetch location. The byte address is the counter shifted left by two. One bit of that byte address picks one of two fetch map registers. The chosen map either sends the fetch to instruction memory or names a unified-memory segment. A fetch to a segment that is not present is flagged as a bus fault. The core pulses the step strobe once per completed instruction. Instruction decoding and the memories are outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: On reset the counter equals RESET_BYTE_ADDR shifted right by 2, and both fetch maps hold 0x1000. The first fetch therefore goes to instruction memory with offset RESET_BYTE_ADDR and no fault.
- R2: A cycle without stepStrobe leaves the counter unchanged.
- R3: On stepStrobe with no branch and no loop-end hit, the counter advances by exactly one.
- R4: On stepStrobe with branchTaken and no loop-end hit, the counter takes branchTarget in the next cycle.
- R5: A loop-end hit happens on stepStrobe when the loop is armed and the counter equals the end word. If the remaining count is above one, the counter reloads the start word and the count drops by one.
- R6: On a loop-end hit with a remaining count of one, the loop disarms and the counter advances to end+1. A later arrival at the end word then advances normally.
- R7: When a loop-end hit and branchTaken happen in the same step, the loop rule wins and branchTarget is ignored.
- R8: A loop setup (loopWrite) with a count of zero leaves the loop disarmed, so the end word does not cause a reload.
- R9: Bit 17 of the byte address (counter bit 15) selects map 1 when set and map 0 when clear. mapWrite with mapSel=0 writes map 0 and with mapSel=1 writes map 1.
- R10: If bit 12 of the selected map is set, fetchToImem is 1, fetchOffset is the byte address, and fetchFault is 0.
- R11: If bit 12 of the selected map is clear, fetchToImem is 0 and fetchSeg is map bits [7:0]. fetchFault is 1 exactly when segPresent[fetchSeg] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepStrobe | input | 1 | One instruction completed |
| branchTaken | input | 1 | The completed instruction branched |
| branchTarget | input | PC_W | Word target of the branch |
| loopWrite | input | 1 | Arm the repeat loop with the three values below |
| loopStart | input | PC_W | First word of the loop body |
| loopEnd | input | PC_W | Last word of the loop body |
| loopCount | input | CNT_W | Number of passes |
| mapWrite | input | 1 | Write a fetch map register |
| mapSel | input | 1 | Which map register to write |
| mapData | input | MAP_W | Value for the map register |
| segPresent | input | SEG_N | One bit per unified segment that exists |
| pc | output | PC_W | Current word counter |
| fetchToImem | output | 1 | Fetch goes to instruction memory |
| fetchSeg | output | SEG_W | Unified segment number of the fetch |
| fetchOffset | output | PC_W+2 | Byte address of the fetch |
| fetchFault | output | 1 | Fetch targets a missing segment |

## Verification
A stale loop count or a wrong armed flag shows at the pc port one cycle after the step that reaches the end word: the counter either reloads the start word when it should fall through, or the reverse. A bad map register or a wrong select bit shows at once on the combinational fetch outputs, as soon as the counter crosses the 128 KiB boundary or a segment bit changes. Because of this, the bench samples pc after every step and checks the fetch outputs at counters on both sides of the select boundary.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic setup;       // capture new loop values
    logic loadStart;   // counter <= loop start word
    logic loadTarget;  // counter <= branch target
    logic advance;     // counter <= counter + 1
    logic decCount;    // remaining passes - 1
    logic exitLoop;    // disarm loop
  } seqCmd_t;
endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    stepStrobe,
  input  logic    branchTaken,
  input  logic    loopWrite,
  input  logic    loopArmed,
  input  logic    atLoopEnd,
  input  logic    lastPass,
  output seqCmd_t cmd
);
  logic loopHit;

  always_comb begin
    loopHit        = stepStrobe && loopArmed && atLoopEnd;
    cmd            = '0;
    cmd.setup      = loopWrite;
    cmd.loadStart  = loopHit && !lastPass;
    cmd.decCount   = loopHit && !lastPass;
    cmd.exitLoop   = loopHit && lastPass;
    cmd.loadTarget = stepStrobe && !loopHit && branchTaken;
    cmd.advance    = (stepStrobe && !loopHit && !branchTaken) || (loopHit && lastPass);
  end

  // R7
  single_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadStart, cmd.loadTarget, cmd.advance}));
endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int CNT_W    = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCmd_t          cmd,
  input  logic [PC_W-1:0]  branchTarget,
  input  logic [PC_W-1:0]  loopStart,
  input  logic [PC_W-1:0]  loopEnd,
  input  logic [CNT_W-1:0] loopCount,
  output logic [PC_W-1:0]  pc,
  output logic             loopArmed,
  output logic             atLoopEnd,
  output logic             lastPass
);
  logic [PC_W-1:0]  pcQ, startQ, endQ;
  logic [CNT_W-1:0] countQ;
  logic             armedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ    <= RESET_PC;
      startQ <= '0;
      endQ   <= '0;
      countQ <= '0;
      armedQ <= 1'b0;
    end else begin
      if (cmd.loadStart)       pcQ <= startQ;
      else if (cmd.loadTarget) pcQ <= branchTarget;
      else if (cmd.advance)    pcQ <= pcQ + PC_W'(1);

      if (cmd.setup) begin
        startQ <= loopStart;
        endQ   <= loopEnd;
        countQ <= loopCount;
        armedQ <= (loopCount != '0);
      end else begin
        if (cmd.decCount) countQ <= countQ - CNT_W'(1);
        if (cmd.exitLoop) armedQ <= 1'b0;
      end
    end
  end

  assign pc        = pcQ;
  assign loopArmed = armedQ;
  assign atLoopEnd = (pcQ == endQ);
  assign lastPass  = (countQ == CNT_W'(1));

  // R8
  armed_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> (countQ != '0));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.loadStart && !cmd.setup) |=> (armedQ && pcQ == startQ));
endmodule

// File: rtl/pcs_fetch_map.sv
module pcs_fetch_map #(
  parameter int PC_W     = 16,
  parameter int MAP_W    = 16,
  parameter int SEG_N    = 256,
  parameter int SEL_BIT  = 17,
  parameter int IMEM_BIT = 12,
  parameter logic [MAP_W-1:0] MAP_RESET = 16'h1000,
  localparam int ADDR_W  = PC_W + 2,
  localparam int SEG_W   = $clog2(SEG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mapWrite,
  input  logic              mapSel,
  input  logic [MAP_W-1:0]  mapData,
  input  logic [SEG_N-1:0]  segPresent,
  input  logic [PC_W-1:0]   pc,
  output logic              fetchToImem,
  output logic [SEG_W-1:0]  fetchSeg,
  output logic [ADDR_W-1:0] fetchOffset,
  output logic              fetchFault
);
  logic [MAP_W-1:0] mapQ [2];
  logic [MAP_W-1:0] activeMap;
  logic [ADDR_W-1:0] byteAddr;

  for (genvar i = 0; i < 2; i++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rstN)                          mapQ[i] <= MAP_RESET;
      else if (mapWrite && (mapSel == i[0])) mapQ[i] <= mapData;
    end
  end

  always_comb begin
    byteAddr    = {pc, 2'b00};
    activeMap   = byteAddr[SEL_BIT] ? mapQ[1] : mapQ[0];
    fetchToImem = activeMap[IMEM_BIT];
    fetchSeg    = activeMap[SEG_W-1:0];
    fetchOffset = byteAddr;
    fetchFault  = !fetchToImem && !segPresent[fetchSeg];
  end

  // R10
  imem_no_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchToImem |-> !fetchFault);
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int CNT_W    = 16,
  parameter int MAP_W    = 16,
  parameter int SEG_N    = 256,
  parameter int SEL_BIT  = 17,
  parameter int IMEM_BIT = 12,
  parameter logic [PC_W+1:0] RESET_BYTE_ADDR = 18'h00100,
  localparam int ADDR_W  = PC_W + 2,
  localparam int SEG_W   = $clog2(SEG_N),
  localparam logic [PC_W-1:0] RESET_PC = RESET_BYTE_ADDR[ADDR_W-1:2]
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepStrobe,
  input  logic              branchTaken,
  input  logic [PC_W-1:0]   branchTarget,
  input  logic              loopWrite,
  input  logic [PC_W-1:0]   loopStart,
  input  logic [PC_W-1:0]   loopEnd,
  input  logic [CNT_W-1:0]  loopCount,
  input  logic              mapWrite,
  input  logic              mapSel,
  input  logic [MAP_W-1:0]  mapData,
  input  logic [SEG_N-1:0]  segPresent,
  output logic [PC_W-1:0]   pc,
  output logic              fetchToImem,
  output logic [SEG_W-1:0]  fetchSeg,
  output logic [ADDR_W-1:0] fetchOffset,
  output logic              fetchFault
);
  seqCmd_t cmd;
  logic loopArmed, atLoopEnd, lastPass;

  pcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stepStrobe(stepStrobe), .branchTaken(branchTaken),
    .loopWrite(loopWrite), .loopArmed(loopArmed), .atLoopEnd(atLoopEnd),
    .lastPass(lastPass), .cmd(cmd)
  );

  pcs_datapath #(.PC_W(PC_W), .CNT_W(CNT_W), .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .branchTarget(branchTarget),
    .loopStart(loopStart), .loopEnd(loopEnd), .loopCount(loopCount),
    .pc(pc), .loopArmed(loopArmed), .atLoopEnd(atLoopEnd), .lastPass(lastPass)
  );

  pcs_fetch_map #(.PC_W(PC_W), .MAP_W(MAP_W), .SEG_N(SEG_N), .SEL_BIT(SEL_BIT),
                  .IMEM_BIT(IMEM_BIT)) u_map (
    .clk(clk), .rstN(rstN), .mapWrite(mapWrite), .mapSel(mapSel), .mapData(mapData),
    .segPresent(segPresent), .pc(pc), .fetchToImem(fetchToImem), .fetchSeg(fetchSeg),
    .fetchOffset(fetchOffset), .fetchFault(fetchFault)
  );

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepStrobe |=> $stable(pc));

  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && !branchTaken && !(loopArmed && atLoopEnd)) |=> (pc == $past(pc) + PC_W'(1)));

  // R4
  branch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && branchTaken && !(loopArmed && atLoopEnd)) |=> (pc == $past(branchTarget)));

  // R11
  fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchFault |-> (!fetchToImem && !segPresent[fetchSeg]));
endmodule

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepStrobe = 0, branchTaken = 0, loopWrite = 0, mapWrite = 0, mapSel = 0;
  logic [15:0] branchTarget = '0, loopStart = '0, loopEnd = '0, loopCount = '0, mapData = '0;
  logic [255:0] segPresent = '0;
  logic [15:0] pc;
  logic fetchToImem, fetchFault;
  logic [7:0] fetchSeg;
  logic [17:0] fetchOffset;
  int passCnt = 0, failCnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rstN(rstN), .stepStrobe(stepStrobe), .branchTaken(branchTaken),
    .branchTarget(branchTarget), .loopWrite(loopWrite), .loopStart(loopStart),
    .loopEnd(loopEnd), .loopCount(loopCount), .mapWrite(mapWrite), .mapSel(mapSel),
    .mapData(mapData), .segPresent(segPresent), .pc(pc), .fetchToImem(fetchToImem),
    .fetchSeg(fetchSeg), .fetchOffset(fetchOffset), .fetchFault(fetchFault)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    if (got === exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic stepOnce(logic br, logic [15:0] tgt);
    stepStrobe = 1; branchTaken = br; branchTarget = tgt;
    @(negedge clk);
    stepStrobe = 0; branchTaken = 0;
  endtask

  task automatic setupLoop(logic [15:0] s, logic [15:0] e, logic [15:0] c);
    loopWrite = 1; loopStart = s; loopEnd = e; loopCount = c;
    @(negedge clk);
    loopWrite = 0;
  endtask

  task automatic writeMap(logic sel, logic [15:0] d);
    mapWrite = 1; mapSel = sel; mapData = d;
    @(negedge clk);
    mapWrite = 0;
  endtask

  task automatic testReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 pc", 32'(pc), 32'h40);
    chk("R1 imem", 32'(fetchToImem), 1);
    chk("R1 offset", 32'(fetchOffset), 32'h100);
    chk("R1 fault", 32'(fetchFault), 0);
  endtask

  task automatic testStepBranch();
    @(negedge clk);
    chk("R2 hold", 32'(pc), 32'h40);
    stepOnce(0, 16'h0);
    chk("R3 advance", 32'(pc), 32'h41);
    stepOnce(1, 16'h1234);
    chk("R4 branch", 32'(pc), 32'h1234);
    stepOnce(0, 16'h0);
    chk("R3 advance after branch", 32'(pc), 32'h1235);
  endtask

  task automatic testLoop();
    setupLoop(16'h50, 16'h52, 16'd3);
    chk("R2 hold during setup", 32'(pc), 32'h1235);
    stepOnce(1, 16'h50);
    for (int pass = 0; pass < 2; pass++) begin
      stepOnce(0, 0); chk("R3 body", 32'(pc), 32'h51);
      stepOnce(0, 0); chk("R3 body end", 32'(pc), 32'h52);
      stepOnce(0, 0); chk("R5 reload", 32'(pc), 32'h50);
    end
    stepOnce(0, 0); stepOnce(0, 0);
    chk("R5 at end", 32'(pc), 32'h52);
    stepOnce(0, 0);
    chk("R6 fall through", 32'(pc), 32'h53);
    stepOnce(1, 16'h52);
    stepOnce(0, 0);
    chk("R6 disarmed", 32'(pc), 32'h53);
  endtask

  task automatic testPriority();
    setupLoop(16'h60, 16'h61, 16'd2);
    stepOnce(1, 16'h61);
    stepOnce(1, 16'h0010);
    chk("R7 loop beats branch", 32'(pc), 32'h60);
  endtask

  task automatic testZeroCount();
    setupLoop(16'h70, 16'h71, 16'd0);
    stepOnce(1, 16'h71);
    stepOnce(0, 0);
    chk("R8 zero count no loop", 32'(pc), 32'h72);
  endtask

  task automatic testMaps();
    writeMap(1, 16'h0005);
    stepOnce(1, 16'h8000);
    chk("R9 map1 selected", 32'(fetchToImem), 0);
    chk("R11 seg", 32'(fetchSeg), 5);
    chk("R11 fault", 32'(fetchFault), 1);
    chk("R11 offset", 32'(fetchOffset), 32'h20000);
    segPresent[5] = 1; #1;
    chk("R11 present no fault", 32'(fetchFault), 0);
    @(negedge clk);
    stepOnce(1, 16'h7FFF);
    chk("R9 map0 selected", 32'(fetchToImem), 1);
    chk("R10 offset", 32'(fetchOffset), 32'h1FFFC);
    chk("R10 no fault", 32'(fetchFault), 0);
    writeMap(0, 16'h0003);
    chk("R9 map0 write", 32'(fetchSeg), 3);
    chk("R11 absent fault", 32'(fetchFault), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testStepBranch();
    testLoop();
    testPriority();
    testZeroCount();
    testMaps();
    done = 1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule